// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block sits in the register file of a UART that has receive and transmit FIFOs. It gathers five interrupt causes and gates each one with its own enable bit. It raises a single active-high interrupt request while any enabled cause is pending. When the host reads the identification register, the block returns a status byte. That byte names only the most urgent pending cause and also shows whether the FIFOs are on and whether the deep (64-entry) FIFO mode is selected.

Three of the causes are events: a receive line error, the transmit holding register going empty, and a modem input change. Each is held in a sticky flag when its input rises. Two causes are level conditions that the FIFO logic drives: receive data available and receive character time-out. A read acknowledges only the cause it reports, so a software loop that reads the register repeatedly walks down through the pending causes in order of urgency.

Top module: `intid_unit`

## Requirements
- R1: After reset, `id_rdata` reads 0x01 and `irq` is 0.
- R2: Causes are ranked from most to least urgent as follows: line error, receive data available, receive time-out, transmit empty, modem change. While a more urgent enabled cause is pending, no less urgent one is reported.
- R3: Bits 3:1 of the status byte carry the reported cause: line error 3'b011, receive data 3'b010, time-out 3'b110, transmit empty 3'b001, modem 3'b000. With nothing pending they read 3'b000.
- R4: Bit 0 of the status byte is 0 when an enabled cause is pending and 1 when none is pending.
- R5: Bits 7:6 both equal `fifo_on`. Bit 5 equals `fifo_on & deep_mode`. Bit 4 is always 0.
- R6: A read clears the latched cause it reports, and only that one. Any other pending cause shows up on the next read.
- R7: The receive-data and time-out causes follow their input levels and are never cleared by a read.
- R8: A latched cause is set on a 0-to-1 transition of its event input. An input that stays high after the acknowledge does not set it again.
- R9: `irq` equals the OR of all enabled pending causes as they stood one clock earlier.
- R10: A disabled cause stays latched but affects neither `irq` nor the status byte. Once it is enabled, it is reported.
- R11: `id_rdata` is loaded at the clock edge where `id_rd` is high. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_err_ev | input | 1 | Receive line error event (latched on rising edge) |
| rx_avail | input | 1 | Receive data available level |
| rx_tmo | input | 1 | Receive character time-out level |
| tx_empty_ev | input | 1 | Transmit holding register empty event (latched on rising edge) |
| modem_ev | input | 1 | Modem input change event (latched on rising edge) |
| cause_en | input | 5 | Enables: [0] line, [1] rx data, [2] time-out, [3] tx empty, [4] modem |
| fifo_on | input | 1 | FIFOs enabled |
| deep_mode | input | 1 | 64-entry FIFO mode selected |
| id_rd | input | 1 | Read strobe for the identification register, one cycle per read |
| id_rdata | output | 8 | Captured status byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is several causes pending at once, with some of them disabled, while reads peel them off one at a time. In that state a wrong acknowledge silently drops a lower cause or clears one that was never reported. Random stimulus keeps event inputs toggling, holds level causes for many cycles and flips enables at a low rate, so deep pending stacks build up between reads. A directed walk then sets every cause, reads it down to the idle code, and covers a masked modem cause, a held event input, and the FIFO flag combinations.

// File: rtl/intid_pkg.sv
package intid_pkg;

  localparam int NCAUSE = 5;
  localparam int NLATCH = 3;

  // cause index = rank (0 most urgent)
  localparam int C_LINE = 0;
  localparam int C_RDAT = 1;
  localparam int C_RTMO = 2;
  localparam int C_TXE  = 3;
  localparam int C_MDM  = 4;

  typedef enum logic [2:0] {
    ID_MODEM = 3'b000,
    ID_TXE   = 3'b001,
    ID_RDAT  = 3'b010,
    ID_LINE  = 3'b011,
    ID_RTMO  = 3'b110
  } id_code_e;

  function automatic id_code_e code_of(input logic [2:0] idx, input logic any);
    id_code_e c;
    if (!any) c = ID_MODEM;
    else begin
      case (idx)
        3'd0:    c = ID_LINE;
        3'd1:    c = ID_RDAT;
        3'd2:    c = ID_RTMO;
        3'd3:    c = ID_TXE;
        default: c = ID_MODEM;
      endcase
    end
    return c;
  endfunction

  function automatic logic [7:0] pack_status(input logic fifo_on, input logic deep,
                                             input logic any, input id_code_e c);
    return {fifo_on, fifo_on, fifo_on & deep, 1'b0, c, ~any};
  endfunction

endpackage

// File: rtl/intid_edge_latch.sv
module intid_edge_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] ack,
  output logic [N-1:0] pend,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= ev;
  end

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign rise[g] = ev[g] & ~prev[g];

    // a fresh event wins over an acknowledge in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend[g] <= 1'b0;
      else if (rise[g]) pend[g] <= 1'b1;
      else if (ack[g])  pend[g] <= 1'b0;
    end

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[g] && !rise[g]) |=> !pend[g]);

    // R8
    rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |=> pend[g]);

    // R8
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend[g] && !rise[g]) |=> !pend[g]);
  end

endmodule

// File: rtl/intid_prio_sel.sv
module intid_prio_sel #(
  parameter int N = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);

  // lowest index is most urgent: scan downward so it is assigned last
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IW'(i);
        any      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/intid_unit.sv
module intid_unit
  import intid_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_err_ev,
  input  logic       rx_avail,
  input  logic       rx_tmo,
  input  logic       tx_empty_ev,
  input  logic       modem_ev,
  input  logic [4:0] cause_en,
  input  logic       fifo_on,
  input  logic       deep_mode,
  input  logic       id_rd,
  output logic [7:0] id_rdata,
  output logic       irq
);

  localparam int IW = $clog2(NCAUSE);

  logic [NLATCH-1:0] lat_ev, lat_ack, lat_pend, lat_rise;
  logic [NCAUSE-1:0] raw_cause, eff_cause, grant;
  logic [IW-1:0]     win_idx;
  logic              any_pend;
  id_code_e          win_code;
  logic [7:0]        status_now;

  // latched slots: 0 line, 1 tx empty, 2 modem
  assign lat_ev = {modem_ev, tx_empty_ev, line_err_ev};

  intid_edge_latch #(.N(NLATCH)) u_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .ev   (lat_ev),
    .ack  (lat_ack),
    .pend (lat_pend),
    .rise (lat_rise)
  );

  always_comb begin
    raw_cause         = '0;
    raw_cause[C_LINE] = lat_pend[0];
    raw_cause[C_RDAT] = rx_avail;
    raw_cause[C_RTMO] = rx_tmo;
    raw_cause[C_TXE]  = lat_pend[1];
    raw_cause[C_MDM]  = lat_pend[2];
  end

  assign eff_cause = raw_cause & cause_en;

  intid_prio_sel #(.N(NCAUSE)) u_sel (
    .req  (eff_cause),
    .grant(grant),
    .idx  (win_idx),
    .any  (any_pend)
  );

  assign win_code   = code_of(3'(win_idx), any_pend);
  assign status_now = pack_status(fifo_on, deep_mode, any_pend, win_code);

  // acknowledge only the reported latched cause
  assign lat_ack = id_rd ? {grant[C_MDM], grant[C_TXE], grant[C_LINE]} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_rdata <= 8'h01;
      irq      <= 1'b0;
    end else begin
      irq <= any_pend;
      if (id_rd) id_rdata <= status_now;
    end
  end

  // R2
  one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any_pend == (|eff_cause)));

  // R2
  no_lower_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[C_TXE] || grant[C_MDM]) |-> !(|eff_cause[C_RTMO:C_LINE]));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|eff_cause)));

  // R4
  idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_rd |=> (id_rdata[0] == !$past(|eff_cause)));

  // R5
  spare_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_rd |=> (id_rdata[4] == 1'b0) && (id_rdata[7] == $past(fifo_on)));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_rd |=> $stable(id_rdata));

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_en == 5'b0) |=> !irq);

endmodule

// File: tb/tb_intid_unit.sv
module tb_intid_unit;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_err_ev = 1'b0, rx_avail = 1'b0, rx_tmo = 1'b0;
  logic       tx_empty_ev = 1'b0, modem_ev = 1'b0;
  logic [4:0] cause_en = 5'b0;
  logic       fifo_on = 1'b0, deep_mode = 1'b0, id_rd = 1'b0;
  logic [7:0] id_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state: latched flags {modem, txe, line}
  logic [2:0] m_pend = 3'b0;
  logic [2:0] m_prev = 3'b0;
  logic [7:0] m_rd = 8'h01;
  logic       m_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intid_unit dut (
    .clk, .rst_n, .line_err_ev, .rx_avail, .rx_tmo, .tx_empty_ev, .modem_ev,
    .cause_en, .fifo_on, .deep_mode, .id_rd, .id_rdata, .irq
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // rank: 0 line, 1 rx data, 2 time-out, 3 tx empty, 4 modem; 5 none
  function automatic int b_pick(input logic [4:0] c);
    if (c[0]) return 0;
    if (c[1]) return 1;
    if (c[2]) return 2;
    if (c[3]) return 3;
    if (c[4]) return 4;
    return 5;
  endfunction

  function automatic logic [7:0] b_status(input int w, input logic fe, input logic dm);
    logic [2:0] code;
    case (w)
      0: code = 3'b011;
      1: code = 3'b010;
      2: code = 3'b110;
      3: code = 3'b001;
      default: code = 3'b000;
    endcase
    return {fe, fe, fe && dm, 1'b0, code, (w == 5)};
  endfunction

  // one clock: inputs applied at a negedge, results checked at the next negedge
  task automatic cyc(input logic [2:0] ev, input logic rdy, input logic tmo,
                     input logic [4:0] en, input logic rd);
    logic [4:0] eff;
    logic [2:0] ack, rise;
    int w;
    {modem_ev, tx_empty_ev, line_err_ev} = ev;
    rx_avail = rdy; rx_tmo = tmo; cause_en = en; id_rd = rd;
    eff = {m_pend[2], m_pend[1], tmo, rdy, m_pend[0]} & en;
    w = b_pick(eff);
    m_irq = (w != 5);
    ack = 3'b0;
    if (rd) begin
      m_rd = b_status(w, fifo_on, deep_mode);
      if (w == 0) ack[0] = 1'b1;
      if (w == 3) ack[1] = 1'b1;
      if (w == 4) ack[2] = 1'b1;
    end
    rise = ev & ~m_prev;
    m_pend = rise | (m_pend & ~ack);
    m_prev = ev;
    @(posedge clk);
    @(negedge clk);
    id_rd = 1'b0;
    chk("R9 irq", {7'b0, irq}, {7'b0, m_irq});
    chk(rd ? "R6 read value" : "R11 held value", id_rdata, m_rd);
  endtask

  initial begin
    void'($urandom(32'h1c0ffee));
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset data", id_rdata, 8'h01);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // directed walk: all causes pending, read them down
    fifo_on = 1'b1; deep_mode = 1'b1;
    cyc(3'b111, 1'b1, 1'b1, 5'h1f, 1'b0);
    cyc(3'b000, 1'b1, 1'b1, 5'h1f, 1'b1);
    chk("R2 R3 line first", id_rdata, 8'hE6);
    cyc(3'b000, 1'b1, 1'b1, 5'h1f, 1'b1);
    chk("R3 rx data", id_rdata, 8'hE4);
    cyc(3'b000, 1'b1, 1'b1, 5'h1f, 1'b1);
    chk("R7 rx data not cleared", id_rdata, 8'hE4);
    cyc(3'b000, 1'b0, 1'b1, 5'h1f, 1'b1);
    chk("R3 time-out", id_rdata, 8'hEC);
    cyc(3'b000, 1'b0, 1'b0, 5'h1f, 1'b1);
    chk("R6 tx empty next", id_rdata, 8'hE2);
    cyc(3'b000, 1'b0, 1'b0, 5'h1f, 1'b1);
    chk("R6 modem next", id_rdata, 8'hE0);
    cyc(3'b000, 1'b0, 1'b0, 5'h1f, 1'b1);
    chk("R4 idle", id_rdata, 8'hE1);

    // R8: held event does not re-latch after acknowledge
    cyc(3'b001, 1'b0, 1'b0, 5'h1f, 1'b0);
    cyc(3'b001, 1'b0, 1'b0, 5'h1f, 1'b1);
    chk("R8 line set", id_rdata, 8'hE6);
    cyc(3'b001, 1'b0, 1'b0, 5'h1f, 1'b0);
    cyc(3'b001, 1'b0, 1'b0, 5'h1f, 1'b1);
    chk("R8 held input no reset", id_rdata, 8'hE1);
    cyc(3'b000, 1'b0, 1'b0, 5'h1f, 1'b0);

    // R10: masked modem cause is kept, then reported
    cyc(3'b100, 1'b0, 1'b0, 5'h0f, 1'b0);
    cyc(3'b000, 1'b0, 1'b0, 5'h0f, 1'b1);
    chk("R10 masked hidden", id_rdata, 8'hE1);
    chk("R10 masked no irq", {7'b0, irq}, 8'h00);
    cyc(3'b000, 1'b0, 1'b0, 5'h1f, 1'b0);
    cyc(3'b000, 1'b0, 1'b0, 5'h1f, 1'b1);
    chk("R10 unmasked shown", id_rdata, 8'hE0);

    // R5: flag combinations
    fifo_on = 1'b0; deep_mode = 1'b1;
    cyc(3'b000, 1'b0, 1'b0, 5'h1f, 1'b1);
    chk("R5 fifo off", id_rdata, 8'h01);
    fifo_on = 1'b1; deep_mode = 1'b0;
    cyc(3'b000, 1'b0, 1'b0, 5'h1f, 1'b1);
    chk("R5 shallow mode", id_rdata, 8'hC1);
    // R11: cause changes without a read leave the byte alone
    cyc(3'b010, 1'b1, 1'b0, 5'h1f, 1'b0);
    chk("R11 no read held", id_rdata, 8'hC1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] ev;
      logic [4:0] en;
      ev = {line_err_ev, tx_empty_ev, modem_ev};
      ev = {modem_ev, tx_empty_ev, line_err_ev};
      for (int b = 0; b < 3; b++) if (($urandom % 6) == 0) ev[b] = ~ev[b];
      en = cause_en;
      if (($urandom % 40) == 0) en = 5'($urandom);
      if (($urandom % 300) == 0) begin
        fifo_on = 1'($urandom); deep_mode = 1'($urandom);
      end
      cyc(ev,
          (($urandom % 10) == 0) ? ~rx_avail : rx_avail,
          (($urandom % 12) == 0) ? ~rx_tmo : rx_tmo,
          en,
          (($urandom % 3) == 0));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule